// File: doc/BRIEF.md
# Serial Flash Command Engine

This block drives a single serial flash device from a small register port. Software fills an address register and a data register, then writes a command word. That one write starts a complete serial command on the pins: an opcode byte, up to three address bytes, up to fifteen dummy bytes, and zero to four data bytes. The data bytes either go out to the flash or are captured from it.

The chip-select line can stay asserted after a command finishes. A long flash transaction is then built from several register-level commands in a chain. The first command carries the opcode. Later commands continue the transaction without re-sending it, and the final command releases the select line. A zero-length command with the hold flag clear simply closes the transaction.

The serial side runs in SPI mode 3, and a timing register sets the SCK period and its edge positions in core clocks. Registers are selected by a word index on `reg_sel`:

| Index | Register |
|---|---|
| 0 | command |
| 1 | address |
| 2 | data |
| 3 | status |
| 4 | timing |

Register reads are combinational.

Top module: `sflash_cmd_engine`

## Requirements
- R1: A write to the command register (index 0) starts a command whose word carries the opcode in bits 7:0, write direction in bit 8 (1 = write), data count in bits 14:9, hold-select in bit 15, dummy count in bits 19:16, address count in bits 22:20 and chip-select index in bits 26:24. The phases go opcode, address, dummy, data, and any phase whose count is zero is skipped.
- R2: The opcode byte is sent only when the command opens a transaction, that is, when chip select is not already held from an earlier command. Every byte is shifted most significant bit first.
- R3: The address phase sends the low N bytes of the address register (index 1), where N is the address count, most significant of those bytes first.
- R4: Dummy bytes drive MOSI low, and whatever MISO carries during them never reaches the data register.
- R5: A write command sends data-register bytes starting with bits 7:0 and moving upward. A data count above 4 is treated as 4, and a write command leaves the data register unchanged.
- R6: A read command stores received byte k into bits 8k+7:8k of the data register (index 2). Lanes beyond the data count keep their earlier value.
- R7: With hold-select set, CS_n stays low after the command and the next command continues the transaction. With it clear, CS_n goes high at the end of the command. A command with no address, dummy or data bytes and hold-select clear inside a transaction sends nothing and only releases CS_n.
- R8: Status bit 22 (pending) reads 1 from the cycle after the command write until the last byte has been shifted. Read data is valid once it clears.
- R9: Status bit 29 (error) is set, and the command is discarded, if a command is written while pending or with a nonzero chip-select index. Writing 1 to bit 29 of the status register (index 3) clears it.
- R10: SCK idles high whenever CS_n is high. MOSI is sampled by the flash on SCK rising edges, and MISO is captured on the rising edge.
- R11: The timing register (index 4) holds the period in bits 3:0, the rise position in bits 11:8 and the fall position in bits 15:12. Its reset value is 0x0102. A period below 2 acts as 2, so consecutive SCK rising edges are exactly one period of core clocks apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 3 | Register word index |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| sck | output | 1 | Serial clock, idle high |
| cs_n | output | 1 | Active-low flash select |
| mosi | output | 1 | Serial data to flash |
| miso | input | 1 | Serial data from flash |

## Verification
The bench models the flash. It records every byte seen on rising SCK edges and returns a position-dependent pattern on MISO, so a design that captured dummy-phase input or used the wrong data lane shows a mismatched data register. Chained commands check that the opcode is not repeated inside a held transaction and that a zero-length closing command releases the select line without clocking. A design that still sent the opcode, or left CS_n low, would fail those checks. Back-to-back command writes and a nonzero select index must raise the error bit and produce no extra bytes on the wire. Random periods including 0 and 1 expose a design that mishandles the minimum SCK period or the edge spacing.

// File: rtl/sfe_pkg.sv
package sfe_pkg;

   // Register word indices on the register port
   localparam int unsigned REG_CMD = 0;
   localparam int unsigned REG_ADR = 1;
   localparam int unsigned REG_DAT = 2;
   localparam int unsigned REG_STA = 3;
   localparam int unsigned REG_TIM = 4;

   // Status bit positions decoded by software
   localparam int unsigned STA_PEND_BIT = 22;
   localparam int unsigned STA_ERR_BIT  = 29;

   typedef enum logic [2:0] {
      PH_IDLE = 3'd0,
      PH_OPC  = 3'd1,
      PH_ADR  = 3'd2,
      PH_DUM  = 3'd3,
      PH_DAT  = 3'd4,
      PH_END  = 3'd5
   } sfe_phase_e;

   typedef struct packed {
      logic [4:0] rsv_hi;
      logic [2:0] csel;
      logic       rsv_23;
      logic [2:0] alen;
      logic [3:0] dum;
      logic       keep;
      logic [5:0] dlen;
      logic       wr;
      logic [7:0] opc;
   } sfe_cmd_t;

   // First phase after 'cur' that has a nonzero count, in fixed order
   function automatic sfe_phase_e sfe_next_phase(input sfe_phase_e cur,
                                                 input logic has_adr,
                                                 input logic has_dum,
                                                 input logic has_dat);
      if (cur < PH_ADR && has_adr) return PH_ADR;
      if (cur < PH_DUM && has_dum) return PH_DUM;
      if (cur < PH_DAT && has_dat) return PH_DAT;
      return PH_END;
   endfunction

endpackage

// File: rtl/sfe_bit_timer.sv
module sfe_bit_timer #(
   parameter int unsigned TW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run,
   input  logic [TW-1:0] per_cfg,
   input  logic [TW-1:0] rise_cfg,
   input  logic [TW-1:0] fall_cfg,
   output logic          sck,
   output logic          smp,
   output logic          bend
);

   localparam logic [TW-1:0] MIN_PER = TW'(2);

   generate
      if (TW < 2 || TW > 4) begin : g_bad_tw
         $error("sfe_bit_timer: TW must be 2..4");
      end
   endgenerate

   logic [TW-1:0] per_e, rise_e, fall_e, cnt_q;

   always_comb begin
      per_e  = (per_cfg < MIN_PER) ? MIN_PER : per_cfg;
      rise_e = (rise_cfg == '0 || rise_cfg >= per_e) ? (per_e >> 1) : rise_cfg;
      fall_e = (fall_cfg >= rise_e) ? '0 : fall_cfg;
   end

   assign bend = run && (cnt_q == per_e - TW'(1));
   assign smp  = run && (cnt_q == rise_e - TW'(1));
   assign sck  = !(run && (cnt_q >= fall_e) && (cnt_q < rise_e));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt_q <= '0;
      else if (!run || bend)  cnt_q <= '0;
      else                    cnt_q <= cnt_q + TW'(1);
   end

   AST_SAMPLE_INSIDE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
      smp |-> !bend); // R10

endmodule

// File: rtl/sfe_seq.sv
module sfe_seq
   import sfe_pkg::*;
#(
   parameter int unsigned DB = 4,
   parameter int unsigned AB = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [7:0]    opc,
   input  logic          wr,
   input  logic [5:0]    dlen,
   input  logic          keep,
   input  logic [3:0]    dum,
   input  logic [2:0]    alen,
   input  logic [8*AB-1:0] addr,
   input  logic [8*DB-1:0] wdata,
   input  logic          miso,
   input  logic          smp,
   input  logic          bend,
   output logic          run,
   output logic          busy,
   output logic          cs_n,
   output logic          mosi,
   output logic          rx_we,
   output logic [2:0]    rx_lane,
   output logic [7:0]    rx_byte
);

   localparam int unsigned CW = 4;

   sfe_phase_e    ph_q, adv_ph, tgt_ph;
   logic [CW-1:0] cnt_q, tgt_cnt, alen_c, dlen_c;
   logic [2:0]    idx_q, tgt_idx, bit_q;
   logic [7:0]    sh_q, rx_q, tgt_sh;
   logic          sel_q, stay, byte_end;

   assign alen_c = (alen > 3'(AB)) ? CW'(AB) : CW'(alen);
   assign dlen_c = (dlen > 6'(DB)) ? CW'(DB) : CW'(dlen);

   assign run      = (ph_q != PH_IDLE) && (ph_q != PH_END);
   assign busy     = (ph_q != PH_IDLE);
   assign byte_end = run && bend && (bit_q == 3'd7);
   assign stay     = !start && (cnt_q > CW'(1));

   always_comb begin
      if (start)
         adv_ph = sel_q ? sfe_next_phase(PH_OPC, alen_c != '0, dum != '0, dlen_c != '0)
                        : PH_OPC;
      else
         adv_ph = sfe_next_phase(ph_q, alen_c != '0, dum != '0, dlen_c != '0);
      tgt_ph = stay ? ph_q : adv_ph;
      if (stay) begin
         tgt_cnt = cnt_q - CW'(1);
         tgt_idx = idx_q + 3'd1;
      end else begin
         tgt_idx = '0;
         case (adv_ph)
            PH_OPC:  tgt_cnt = CW'(1);
            PH_ADR:  tgt_cnt = alen_c;
            PH_DUM:  tgt_cnt = dum;
            PH_DAT:  tgt_cnt = dlen_c;
            default: tgt_cnt = '0;
         endcase
      end
      case (tgt_ph)
         PH_OPC:  tgt_sh = opc;
         PH_ADR:  tgt_sh = 8'(addr >> {tgt_cnt - CW'(1), 3'b000});
         PH_DAT:  tgt_sh = wr ? 8'(wdata >> {tgt_idx, 3'b000}) : 8'h00;
         default: tgt_sh = 8'h00;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q  <= PH_IDLE;
         cnt_q <= '0;
         idx_q <= '0;
         bit_q <= '0;
         sh_q  <= '0;
         rx_q  <= '0;
         sel_q <= 1'b0;
      end else begin
         if (start || byte_end) begin
            ph_q  <= tgt_ph;
            cnt_q <= tgt_cnt;
            idx_q <= tgt_idx;
            sh_q  <= tgt_sh;
            bit_q <= '0;
            if (start) sel_q <= 1'b1;
         end else if (run && bend) begin
            bit_q <= bit_q + 3'd1;
            sh_q  <= {sh_q[6:0], 1'b0};
         end else if (ph_q == PH_END) begin
            ph_q <= PH_IDLE;
            if (!keep) sel_q <= 1'b0;
         end
         if (run && smp) rx_q <= {rx_q[6:0], miso};
      end
   end

   assign cs_n    = !sel_q;
   assign mosi    = run & sh_q[7];
   assign rx_we   = byte_end && (ph_q == PH_DAT) && !wr;
   assign rx_lane = idx_q;
   assign rx_byte = rx_q;

   AST_SELECTED_WHILE_SHIFTING: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> !cs_n); // R7
   AST_DUMMY_DRIVES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (ph_q == PH_DUM) |-> !mosi); // R4
   AST_RX_LANE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      rx_we |-> (rx_lane < 3'(DB))); // R6

endmodule

// File: rtl/sflash_cmd_engine.sv
module sflash_cmd_engine
   import sfe_pkg::*;
#(
   parameter int unsigned DATA_BYTES = 4,
   parameter int unsigned ADDR_BYTES = 3,
   parameter int unsigned TIME_W     = 4
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic [2:0]  reg_sel,
   input  logic        reg_we,
   input  logic [31:0] reg_wdata,
   output logic [31:0] reg_rdata,
   output logic        sck,
   output logic        cs_n,
   output logic        mosi,
   input  logic        miso
);

   localparam int unsigned DW = 8 * DATA_BYTES;
   localparam int unsigned AW = 8 * ADDR_BYTES;
   localparam logic [TIME_W-1:0] PER_RST  = TIME_W'(2);
   localparam logic [TIME_W-1:0] RISE_RST = TIME_W'(1);

   generate
      if (DATA_BYTES < 1 || DATA_BYTES > 4) begin : g_bad_db
         $error("sflash_cmd_engine: DATA_BYTES must be 1..4");
      end
      if (ADDR_BYTES < 1 || ADDR_BYTES > 3) begin : g_bad_ab
         $error("sflash_cmd_engine: ADDR_BYTES must be 1..3");
      end
   endgenerate

   sfe_cmd_t          cmd_q, cmd_in;
   logic [AW-1:0]     adr_q;
   logic [DW-1:0]     dat_q;
   logic [TIME_W-1:0] per_q, rise_q, fall_q;
   logic              err_q, start_q, pend, busy, run, smp, bend;
   logic              cmd_hit, accept, err_clr, rx_we;
   logic [2:0]        rx_lane;
   logic [7:0]        rx_byte;

   assign cmd_in  = sfe_cmd_t'(reg_wdata);
   assign pend    = start_q | busy;
   assign cmd_hit = reg_we && (reg_sel == 3'(REG_CMD));
   assign accept  = cmd_hit && !pend && (cmd_in.csel == 3'd0);
   assign err_clr = reg_we && (reg_sel == 3'(REG_STA)) && reg_wdata[STA_ERR_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_q   <= '0;
         adr_q   <= '0;
         err_q   <= 1'b0;
         start_q <= 1'b0;
         per_q   <= PER_RST;
         rise_q  <= RISE_RST;
         fall_q  <= '0;
      end else begin
         start_q <= accept;
         if (accept) cmd_q <= cmd_in;
         if (cmd_hit && !accept) err_q <= 1'b1;
         else if (err_clr)       err_q <= 1'b0;
         if (reg_we && reg_sel == 3'(REG_ADR)) adr_q <= reg_wdata[AW-1:0];
         if (reg_we && reg_sel == 3'(REG_TIM)) begin
            per_q  <= reg_wdata[0  +: TIME_W];
            rise_q <= reg_wdata[8  +: TIME_W];
            fall_q <= reg_wdata[12 +: TIME_W];
         end
      end
   end

   // One update path per data byte lane: captured flash data wins over a host write
   for (genvar gl = 0; gl < DATA_BYTES; gl++) begin : g_lane
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            dat_q[8*gl +: 8] <= '0;
         else if (rx_we && rx_lane == 3'(gl))
            dat_q[8*gl +: 8] <= rx_byte;
         else if (reg_we && reg_sel == 3'(REG_DAT))
            dat_q[8*gl +: 8] <= reg_wdata[8*gl +: 8];
      end
   end

   always_comb begin
      reg_rdata = '0;
      case (reg_sel)
         3'(REG_CMD): reg_rdata = cmd_q;
         3'(REG_ADR): reg_rdata[AW-1:0] = adr_q;
         3'(REG_DAT): reg_rdata[DW-1:0] = dat_q;
         3'(REG_STA): begin
            reg_rdata[STA_PEND_BIT] = pend;
            reg_rdata[STA_ERR_BIT]  = err_q;
         end
         3'(REG_TIM): begin
            reg_rdata[0  +: TIME_W] = per_q;
            reg_rdata[8  +: TIME_W] = rise_q;
            reg_rdata[12 +: TIME_W] = fall_q;
         end
         default: reg_rdata = '0;
      endcase
   end

   sfe_bit_timer #(.TW(TIME_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (run),
      .per_cfg  (per_q),
      .rise_cfg (rise_q),
      .fall_cfg (fall_q),
      .sck      (sck),
      .smp      (smp),
      .bend     (bend)
   );

   sfe_seq #(.DB(DATA_BYTES), .AB(ADDR_BYTES)) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start_q),
      .opc     (cmd_q.opc),
      .wr      (cmd_q.wr),
      .dlen    (cmd_q.dlen),
      .keep    (cmd_q.keep),
      .dum     (cmd_q.dum),
      .alen    (cmd_q.alen),
      .addr    (adr_q),
      .wdata   (dat_q),
      .miso    (miso),
      .smp     (smp),
      .bend    (bend),
      .run     (run),
      .busy    (busy),
      .cs_n    (cs_n),
      .mosi    (mosi),
      .rx_we   (rx_we),
      .rx_lane (rx_lane),
      .rx_byte (rx_byte)
   );

   AST_START_ONLY_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      start_q |-> !busy); // R9
   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (err_q && !err_clr) |=> err_q); // R9
   AST_RELEASE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(pend) && !cmd_q.keep) |-> cs_n); // R7
   AST_SCK_HIGH_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> sck); // R10

endmodule

// File: tb/sflash_cmd_engine_bench.sv
module sflash_cmd_engine_bench;
   import sfe_pkg::*;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  reg_sel = '0;
   logic        reg_we = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        sck, cs_n, mosi;
   logic        miso = 1'b0;

   int checks = 0;
   int fails  = 0;
   bit txn_m  = 1'b0;

   logic [7:0] got [0:31];
   int         ncap = 0;
   int         nbit = 0;
   int         mbit = 0;
   logic [7:0] acc  = '0;
   realtime    t_prev = 0, t_last = 0;

   always #4 clk = ~clk;

   sflash_cmd_engine u_sflash_cmd_engine (
      .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_we(reg_we),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .sck(sck), .cs_n(cs_n), .mosi(mosi), .miso(miso)
   );

   function automatic logic [7:0] mf(input int k);
      return 8'(k * 37 + 8'h3C);
   endfunction

   // Flash model: capture on rising SCK, drive on falling SCK
   always @(posedge sck) begin
      t_prev = t_last;
      t_last = $realtime;
      if (!cs_n) begin
         acc = {acc[6:0], mosi};
         nbit++;
         if (nbit % 8 == 0) begin
            if (ncap < 32) got[ncap] = acc;
            ncap++;
         end
      end
   end

   always @(negedge sck) begin
      logic [7:0] b;
      b = mf(mbit / 8);
      miso = b[7 - (mbit % 8)];
      mbit++;
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic wr(input int s, input logic [31:0] d);
      @(negedge clk);
      reg_sel = 3'(s); reg_we = 1'b1; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input int s, output logic [31:0] d);
      @(negedge clk);
      reg_sel = 3'(s);
      #1 d = reg_rdata;
   endtask

   task automatic wait_idle;
      logic [31:0] st;
      for (int i = 0; i < 4000; i++) begin
         rd(REG_STA, st);
         if (!st[STA_PEND_BIT]) break;
      end
   endtask

   function automatic logic [31:0] cmd_word(input logic [7:0] opc, input bit w, input int dl,
                                            input bit kp, input int dm, input int al, input int cs);
      return {5'b0, 3'(cs), 1'b0, 3'(al), 4'(dm), kp, 6'(dl), w, opc};
   endfunction

   task automatic run_cmd(input logic [7:0] opc, input bit w, input int dl, input bit kp,
                          input int dm, input int al, input logic [23:0] a, input logic [31:0] d);
      logic [7:0]  exp [0:31];
      logic [31:0] st, rdv, expd;
      int ne, dlc, nd, bad;
      wr(REG_ADR, {8'h0, a});
      wr(REG_DAT, d);
      ncap = 0; nbit = 0; mbit = 0;
      dlc = (dl > 4) ? 4 : dl;
      ne = 0;
      if (!txn_m) begin exp[ne] = opc; ne++; end
      for (int i = al - 1; i >= 0; i--) begin exp[ne] = a[8*i +: 8]; ne++; end
      for (int i = 0; i < dm; i++) begin exp[ne] = 8'h00; ne++; end
      nd = ne;
      for (int j = 0; j < dlc; j++) begin exp[ne] = w ? d[8*j +: 8] : 8'h00; ne++; end
      wr(REG_CMD, cmd_word(opc, w, dl, kp, dm, al, 0));
      rd(REG_STA, st);
      chk(st[STA_PEND_BIT] == 1'b1, "R8 pending after command write", st, 32'h0040_0000);
      wait_idle();
      chk(ncap == ne, "R1 R2 R7 byte count", 32'(ncap), 32'(ne));
      bad = -1;
      for (int i = 0; i < ne && i < 32; i++)
         if (bad < 0 && got[i] !== exp[i]) bad = i;
      chk(bad < 0, "R2 R3 R4 R5 byte stream",
          (bad < 0) ? 32'h0 : {24'h0, got[bad]}, (bad < 0) ? 32'h0 : {24'h0, exp[bad]});
      rd(REG_DAT, rdv);
      expd = d;
      if (!w) for (int j = 0; j < dlc; j++) expd[8*j +: 8] = mf(nd + j);
      chk(rdv == expd, w ? "R5 data reg kept on write" : "R6 R4 read data lanes", rdv, expd);
      chk(cs_n == !kp, "R7 select after command", {31'b0, cs_n}, {31'b0, !kp});
      chk(sck == 1'b1, "R10 sck idle high", {31'b0, sck}, 32'h1);
      txn_m = kp;
   endtask

   initial begin
      logic [31:0] v;
      void'($urandom(32'd2024));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // Reset state
      rd(REG_STA, v);  chk(v == 32'h0, "R8 R9 status at reset", v, 32'h0);
      rd(REG_TIM, v);  chk(v == 32'h0000_0102, "R11 timing reset value", v, 32'h0000_0102);
      chk(cs_n == 1'b1, "R7 cs_n at reset", {31'b0, cs_n}, 32'h1);
      chk(sck == 1'b1, "R10 sck at reset", {31'b0, sck}, 32'h1);

      // Directed: full command with default timing, period check
      run_cmd(8'h9F, 1'b0, 3, 1'b0, 1, 3, 24'hA1B2C3, 32'hDEADBEEF);
      chk(t_last - t_prev == 16.0, "R11 default period 2 clocks", 32'(int'(t_last - t_prev)), 32'd16);

      wr(REG_TIM, 32'h0000_0205);
      run_cmd(8'h03, 1'b0, 4, 1'b0, 0, 2, 24'h00_5A_A5, 32'h11223344);
      chk(t_last - t_prev == 40.0, "R11 period 5 clocks", 32'(int'(t_last - t_prev)), 32'd40);

      wr(REG_TIM, 32'h0000_3F01);
      run_cmd(8'h02, 1'b1, 2, 1'b0, 0, 1, 24'h000077, 32'hCAFEF00D);
      chk(t_last - t_prev == 16.0, "R11 period field 1 acts as 2", 32'(int'(t_last - t_prev)), 32'd16);
      wr(REG_TIM, 32'h0000_0102);

      // R5 count above four, long dummy run for R4
      run_cmd(8'h32, 1'b1, 6, 1'b0, 0, 0, 24'h0, 32'h89ABCDEF);
      run_cmd(8'h6B, 1'b0, 2, 1'b0, 15, 3, 24'h123456, 32'h55555555);

      // R7 chained transaction: opcode once, then continuation, then release-only command
      run_cmd(8'h0B, 1'b0, 0, 1'b1, 1, 3, 24'h010203, 32'h0);
      run_cmd(8'hEE, 1'b0, 4, 1'b1, 0, 0, 24'h0, 32'hFFFF0000);
      run_cmd(8'hEE, 1'b1, 3, 1'b1, 0, 0, 24'h0, 32'h00C0FFEE);
      run_cmd(8'hEE, 1'b0, 0, 1'b0, 0, 0, 24'h0, 32'h0);

      // R9 command while pending
      wr(REG_ADR, 32'h0);
      ncap = 0; nbit = 0; mbit = 0;
      wr(REG_CMD, cmd_word(8'hAB, 1'b1, 0, 1'b0, 0, 0, 0));
      wr(REG_CMD, cmd_word(8'hCD, 1'b1, 0, 1'b0, 0, 0, 0));
      wait_idle();
      rd(REG_STA, v);
      chk(v[STA_ERR_BIT] == 1'b1, "R9 error on command while pending", v, 32'h2000_0000);
      chk(ncap == 1 && got[0] == 8'hAB, "R9 second command discarded", 32'(ncap), 32'd1);
      wr(REG_STA, 32'h2000_0000);
      rd(REG_STA, v);
      chk(v == 32'h0, "R9 error cleared by writing one", v, 32'h0);

      // R9 nonzero chip-select index
      ncap = 0; nbit = 0;
      wr(REG_CMD, cmd_word(8'h9F, 1'b0, 2, 1'b0, 0, 0, 1));
      repeat (40) @(negedge clk);
      rd(REG_STA, v);
      chk(v == 32'h2000_0000, "R9 bad select index flags error only", v, 32'h2000_0000);
      chk(ncap == 0 && cs_n == 1'b1, "R9 bad select index not executed", 32'(ncap), 32'd0);
      wr(REG_STA, 32'h2000_0000);

      // Random commands over random timing
      for (int n = 0; n < 40; n++) begin
         logic [31:0] tim;
         tim = {16'h0, 4'($urandom % 16), 4'($urandom % 16), 4'h0, 4'($urandom % 7)};
         wr(REG_TIM, tim);
         run_cmd(8'($urandom), 1'($urandom), int'($urandom % 6), 1'($urandom),
                 int'($urandom % 4), int'($urandom % 4), 24'($urandom), $urandom);
      end
      if (txn_m) run_cmd(8'h00, 1'b0, 0, 1'b0, 0, 0, 24'h0, 32'h0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog R8 act=still_running exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule